// File: doc/BRIEF.md
# USB Host Glue Control and Interrupt Unit

This register block sits beside a USB host core and handles the glue around it. Four 32-bit registers sit on a simple register bus: a control register, a status register whose bits are cleared by writing one, an interrupt enable register and an interrupt test register. The control register drives two resets. The bus-interface reset clears itself after a fixed number of clocks. The core reset stays asserted until software clears it. The control register also selects the period of a frame tick, which is a millisecond in normal operation and can be shrunk to a microsecond to speed up simulation. It also sets the polarity of the over-current sense and power-enable signals of three downstream ports, and drives the sleep controls of those ports.

Hardware events from the core raise bits in the status register. Any raised status bit whose enable is set drives one registered interrupt line. In test mode, software can raise status bits directly through the test register, so the interrupt path can be checked without real events.

The bus is a single-cycle write strobe with a word select. Reads are combinational. Select 0 is control, 1 is status, 2 is enable and 3 is test.

Top module: `usbh_glue_ctrl`

## Requirements
- R1: After synchronous reset, the control register reads 0x00000002 and the status, enable and test registers read 0. `core_rst_o` is 1, and `irq_o`, `sbr_rst_o` and `tick_o` are 0.
- R2: Writing a 1 to control bit 0 asserts `sbr_rst_o` and control bit 0 for exactly SBR_CYCLES (3) clocks after the write edge. Both then return to 0 without further writes. Writing 0 to the bit has no effect.
- R3: `core_rst_o` equals control bit 1 and keeps the value software last wrote to it.
- R4: `tick_o` is a one-clock pulse every MS_DIV clocks when control bit 3 is 0, and every US_DIV clocks when it is 1.
- R5: For each port p, `oc_core_o[p]` is `oc_pin_i[p]` inverted when control bit 6 is 1 and passed through when it is 0. `pwr_pin_o[p]` is `pwr_core_i[p]` inverted when control bit 7 is 1 and passed through when it is 0.
- R6: `sleep_o[p]` is 1 when control bit 5 or control bit 9+p is 1.
- R7: A 1 on `evt_in` at a status position (7, 8, 10 to 16) sets that status bit at the next clock, and the bit stays set. Writing 1 to a status bit clears it, and writing 0 leaves it alone. Every other status position reads 0.
- R8: If an event and a write-one-to-clear hit the same status bit in the same clock, the bit ends up set.
- R9: The enable register keeps bits 7, 8 and 10 to 14. All other enable bits read 0.
- R10: `irq_o` is a register that is 1 when some enabled status bit is set. Status bits 7, 8 and 10 to 13 pair with the enable bit of the same number. Status bit 16 pairs with enable bit 14. Status bits 14 and 15 never raise `irq_o`. `irq_o` is updated at the same edge as the status bits.
- R11: A write to the test register sets status bits wherever the write data has a 1 at a status position, but only while control bit 4 is 1. When control bit 4 is 0, such a write changes nothing. The test register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select (0 control, 1 status, 2 enable, 3 test) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| evt_in | input | 32 | Event pulses aligned to status bit positions |
| oc_pin_i | input | 3 | Raw over-current sense from the port power switches |
| oc_core_o | output | 3 | Polarity-corrected over-current, active high, to the core |
| pwr_core_i | input | 3 | Active-high power enables from the core |
| pwr_pin_o | output | 3 | Polarity-adjusted power enables to the switches |
| sleep_o | output | 3 | Per-port sleep/standby controls |
| sbr_rst_o | output | 1 | Self-clearing bus-interface reset |
| core_rst_o | output | 1 | Held host core reset |
| tick_o | output | 1 | Frame tick pulse |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The assertions check these behaviours on every cycle:
- the bus-interface reset drops on its own at the end of its window;
- unused status and enable positions stay 0;
- a set request is never lost to a clear;
- the interrupt register agrees with the status and enable state;
- the tick is a single-clock pulse within its divider range;
- the core reset comes out of reset asserted.

Only the bench scenarios can show:
- the exact tick period in each scale mode;
- the mapping of the port 3 status bit to its enable bit at 14;
- that test writes are dropped while test mode is off;
- the per-port polarity and sleep patterns seen at the pins.

// File: rtl/usbh_glue_pkg.sv
package usbh_glue_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_PORTS = 3;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_IEN  = 2'd2,
        SEL_TEST = 2'd3
    } reg_sel_e;

    // control bit positions
    localparam int CB_SBR       = 0;
    localparam int CB_CORE_RST  = 1;
    localparam int CB_SCALE     = 3;
    localparam int CB_TEST_EN   = 4;
    localparam int CB_SLEEP_ALL = 5;
    localparam int CB_OC_POL    = 6;
    localparam int CB_PWR_POL   = 7;
    localparam int CB_SLEEP_P0  = 9;

    // plain read/write control bits (bit 0 is handled by the pulse logic)
    localparam logic [DATA_W-1:0] CTL_WMASK  = 32'h0000_0EFA;
    localparam logic [DATA_W-1:0] CTL_RSTVAL = 32'h0000_0002;

    // status positions: 7, 8, 10..16
    localparam logic [DATA_W-1:0] STAT_MASK = 32'h0001_FD80;
    // enable positions: 7, 8, 10..14
    localparam logic [DATA_W-1:0] IEN_MASK  = 32'h0000_7D80;
    // enables that pair with the status bit of the same number
    localparam logic [DATA_W-1:0] IEN_SAME  = 32'h0000_3D80;
    localparam int IEN_P3  = 14;
    localparam int STAT_P3 = 16;

    typedef struct packed {
        logic [NUM_PORTS-1:0] sleep_port;
        logic                 pwr_pol;
        logic                 oc_pol;
        logic                 sleep_all;
        logic                 test_en;
        logic                 scale;
        logic                 core_rst;
        logic                 sbr;
    } ctl_fields_t;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic ctl_fields_t ctl_decode(input logic [DATA_W-1:0] r);
        ctl_fields_t f;
        f.sleep_port = r[CB_SLEEP_P0 +: NUM_PORTS];
        f.pwr_pol    = r[CB_PWR_POL];
        f.oc_pol     = r[CB_OC_POL];
        f.sleep_all  = r[CB_SLEEP_ALL];
        f.test_en    = r[CB_TEST_EN];
        f.scale      = r[CB_SCALE];
        f.core_rst   = r[CB_CORE_RST];
        f.sbr        = r[CB_SBR];
        return f;
    endfunction

    // move enables onto the status positions they gate
    function automatic logic [DATA_W-1:0] ien_to_stat(input logic [DATA_W-1:0] ien);
        logic [DATA_W-1:0] r;
        r          = ien & IEN_SAME;
        r[STAT_P3] = ien[IEN_P3];
        return r;
    endfunction

endpackage

// File: rtl/glue_ctl_reg.sv
module glue_ctl_reg
    import usbh_glue_pkg::*;
#(
    parameter int SBR_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_q
);
    localparam int CNT_W = $clog2(SBR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SBR_CYCLES - 1);

    logic [DATA_W-1:0] ctl_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              sbr_start;

    assign sbr_start = wr_ctl && wdata[CB_SBR];

    always_comb begin
        ctl_d = ctl_q;
        cnt_d = cnt_q;
        if (wr_ctl) begin
            ctl_d = (ctl_q & ~CTL_WMASK) | (wdata & CTL_WMASK);
        end
        if (sbr_start) begin
            ctl_d[CB_SBR] = 1'b1;
            cnt_d         = '0;
        end else if (ctl_q[CB_SBR]) begin
            if (cnt_q == CNT_LAST) begin
                ctl_d[CB_SBR] = 1'b0;
                cnt_d         = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RSTVAL;
            cnt_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            cnt_q <= cnt_d;
        end
    end

    // R2: the pulse ends by itself at the last count
    assert_sbr_selfclear_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[CB_SBR] && cnt_q == CNT_LAST && !sbr_start) |=> !ctl_q[CB_SBR]);

    // R2: a started pulse lasts more than one clock
    assert_sbr_holds_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctl_q[CB_SBR]) && !wr_ctl) |=> ctl_q[CB_SBR]);

    // R1: the core reset is asserted on the first cycle out of reset
    assert_core_rst_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> ctl_q[CB_CORE_RST]);

endmodule

// File: rtl/glue_tick_gen.sv
module glue_tick_gen #(
    parameter int MS_DIV = 50000,
    parameter int US_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic scale,
    output logic tick
);
    localparam int CNT_W = $clog2(MS_DIV + 1);
    localparam logic [CNT_W-1:0] MS_LAST = CNT_W'(MS_DIV - 1);
    localparam logic [CNT_W-1:0] US_LAST = CNT_W'(US_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = scale ? US_LAST : MS_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= limit) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R4: the tick is a single-clock pulse
    assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R4: the counter never runs past the slow divider
    assert_tick_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= MS_LAST);

endmodule

// File: rtl/glue_irq_unit.sv
module glue_irq_unit
    import usbh_glue_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat,
    input  logic              wr_ien,
    input  logic              wr_test,
    input  logic              test_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] ien_q,
    output logic              irq
);
    logic [DATA_W-1:0] set_vec, clr_vec, stat_d, ien_d;

    always_comb begin
        set_vec = evt & STAT_MASK;
        if (wr_test && test_en) begin
            set_vec = set_vec | (wdata & STAT_MASK);
        end
        clr_vec = wr_stat ? (wdata & STAT_MASK) : '0;
        // set beats clear
        stat_d  = ((stat_q & ~clr_vec) | set_vec) & STAT_MASK;
        ien_d   = wr_ien ? (wdata & IEN_MASK) : ien_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            ien_q  <= '0;
            irq    <= 1'b0;
        end else begin
            stat_q <= stat_d;
            ien_q  <= ien_d;
            irq    <= |(stat_d & ien_to_stat(ien_d));
        end
    end

    // R8: a requested set is always present afterwards
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

    // R7: unused status positions stay clear
    assert_stat_unused_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_q & ~STAT_MASK) == '0);

    // R9: unused enable positions stay clear
    assert_ien_unused_R9: assert property (@(posedge clk) disable iff (rst)
        (ien_q & ~IEN_MASK) == '0);

    // R10: the interrupt register agrees with the state it summarises
    assert_irq_consistent_R10: assert property (@(posedge clk) disable iff (rst)
        irq == |(stat_q & ien_to_stat(ien_q)));

    // R10: status bits 14 and 15 alone never interrupt
    assert_sba_no_irq_R10: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~32'h0000_C000) == '0) |-> !irq);

endmodule

// File: rtl/glue_port_pads.sv
module glue_port_pads #(
    parameter int NP = 3
) (
    input  logic          oc_pol,
    input  logic          pwr_pol,
    input  logic          sleep_all,
    input  logic [NP-1:0] sleep_port,
    input  logic [NP-1:0] oc_pin,
    input  logic [NP-1:0] pwr_core,
    output logic [NP-1:0] oc_core,
    output logic [NP-1:0] pwr_pin,
    output logic [NP-1:0] sleep
);
    for (genvar p = 0; p < NP; p++) begin : g_port
        assign oc_core[p] = oc_pin[p] ^ oc_pol;
        assign pwr_pin[p] = pwr_core[p] ^ pwr_pol;
        assign sleep[p]   = sleep_all | sleep_port[p];
    end
endmodule

// File: rtl/usbh_glue_ctrl.sv
module usbh_glue_ctrl
    import usbh_glue_pkg::*;
#(
    parameter int SBR_CYCLES = 3,
    parameter int MS_DIV     = 50000,
    parameter int US_DIV     = 50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [1:0]           bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [DATA_W-1:0]    evt_in,
    input  logic [NUM_PORTS-1:0] oc_pin_i,
    output logic [NUM_PORTS-1:0] oc_core_o,
    input  logic [NUM_PORTS-1:0] pwr_core_i,
    output logic [NUM_PORTS-1:0] pwr_pin_o,
    output logic [NUM_PORTS-1:0] sleep_o,
    output logic                 sbr_rst_o,
    output logic                 core_rst_o,
    output logic                 tick_o,
    output logic                 irq_o
);
    bus_req_t          req;
    ctl_fields_t       cf;
    logic [DATA_W-1:0] ctl_q, stat_q, ien_q;

    assign req.we    = bus_we;
    assign req.sel   = reg_sel_e'(bus_addr);
    assign req.wdata = bus_wdata;

    assign cf = ctl_decode(ctl_q);

    glue_ctl_reg #(.SBR_CYCLES(SBR_CYCLES)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wr_ctl (req.we && req.sel == SEL_CTL),
        .wdata  (req.wdata),
        .ctl_q  (ctl_q)
    );

    glue_tick_gen #(.MS_DIV(MS_DIV), .US_DIV(US_DIV)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .scale (cf.scale),
        .tick  (tick_o)
    );

    glue_irq_unit u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_stat (req.we && req.sel == SEL_STAT),
        .wr_ien  (req.we && req.sel == SEL_IEN),
        .wr_test (req.we && req.sel == SEL_TEST),
        .test_en (cf.test_en),
        .wdata   (req.wdata),
        .evt     (evt_in),
        .stat_q  (stat_q),
        .ien_q   (ien_q),
        .irq     (irq_o)
    );

    glue_port_pads #(.NP(NUM_PORTS)) u_pads (
        .oc_pol     (cf.oc_pol),
        .pwr_pol    (cf.pwr_pol),
        .sleep_all  (cf.sleep_all),
        .sleep_port (cf.sleep_port),
        .oc_pin     (oc_pin_i),
        .pwr_core   (pwr_core_i),
        .oc_core    (oc_core_o),
        .pwr_pin    (pwr_pin_o),
        .sleep      (sleep_o)
    );

    assign sbr_rst_o  = cf.sbr;
    assign core_rst_o = cf.core_rst;

    always_comb begin
        case (req.sel)
            SEL_CTL:  bus_rdata = ctl_q;
            SEL_STAT: bus_rdata = stat_q;
            SEL_IEN:  bus_rdata = ien_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/usbh_glue_ctrl_bench.sv
module usbh_glue_ctrl_bench;
    localparam int MS_DIV = 400;
    localparam int US_DIV = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_in = '0;
    logic [2:0]  oc_pin_i = '0;
    logic [2:0]  oc_core_o;
    logic [2:0]  pwr_core_i = '0;
    logic [2:0]  pwr_pin_o;
    logic [2:0]  sleep_o;
    logic        sbr_rst_o, core_rst_o, tick_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    usbh_glue_ctrl #(.SBR_CYCLES(3), .MS_DIV(MS_DIV), .US_DIV(US_DIV)) u_usbh_glue_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .oc_pin_i(oc_pin_i), .oc_core_o(oc_core_o), .pwr_core_i(pwr_core_i),
        .pwr_pin_o(pwr_pin_o), .sleep_o(sleep_o), .sbr_rst_o(sbr_rst_o),
        .core_rst_o(core_rst_o), .tick_o(tick_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 ctl", v, 32'h2);
        rd(2'd1, v); check("R1 stat", v, 32'h0);
        rd(2'd2, v); check("R1 ien", v, 32'h0);
        rd(2'd3, v); check("R1 test", v, 32'h0);
        check("R1 pins", {28'd0, core_rst_o, irq_o, sbr_rst_o, tick_o}, 32'h8);
    endtask

    task automatic t_sbr();
        logic [31:0] v;
        int hi = 0;
        wr(2'd0, 32'h3);
        for (int i = 0; i < 8; i++) begin
            if (sbr_rst_o) hi++;
            cyc();
        end
        check("R2 pulse length", hi, 3);
        rd(2'd0, v); check("R2 bit clears", v, 32'h2);
        wr(2'd0, 32'h2);
        check("R2 write zero no pulse", {31'd0, sbr_rst_o}, 0);
    endtask

    task automatic t_core_rst();
        wr(2'd0, 32'h0);
        check("R3 core reset released", {31'd0, core_rst_o}, 0);
        wr(2'd0, 32'h2);
        check("R3 core reset set", {31'd0, core_rst_o}, 1);
        wr(2'd0, 32'h0);
    endtask

    task automatic measure(input logic scale, input int exp, input string tag);
        int n = 0;
        wr(2'd0, scale ? 32'h8 : 32'h0);
        while (!tick_o) cyc();
        do begin cyc(); n++; end while (!tick_o && n < 5000);
        check(tag, n, exp);
    endtask

    task automatic t_tick();
        measure(1'b0, MS_DIV, "R4 slow period");
        measure(1'b1, US_DIV, "R4 fast period");
        wr(2'd0, 32'h0);
    endtask

    task automatic t_pads();
        oc_pin_i = 3'b101; pwr_core_i = 3'b011;
        wr(2'd0, 32'h0);
        #1;
        check("R5 oc pass", oc_core_o, 3'b101);
        check("R5 pwr pass", pwr_pin_o, 3'b011);
        wr(2'd0, 32'h40); #1;
        check("R5 oc invert", oc_core_o, 3'b010);
        check("R5 pwr untouched", pwr_pin_o, 3'b011);
        wr(2'd0, 32'h80); #1;
        check("R5 pwr invert", pwr_pin_o, 3'b100);
        check("R5 oc untouched", oc_core_o, 3'b101);
        wr(2'd0, 32'h400); #1;
        check("R6 port2 sleep", sleep_o, 3'b010);
        wr(2'd0, 32'h0A00); #1;
        check("R6 ports 1,3 sleep", sleep_o, 3'b101);
        wr(2'd0, 32'h20); #1;
        check("R6 global sleep", sleep_o, 3'b111);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        evt_in = 32'hFFFF_FFFF;
        cyc();
        evt_in = '0;
        rd(2'd1, v); check("R7 event set mask", v, 32'h0001_FD80);
        cyc();
        rd(2'd1, v); check("R7 sticky", v, 32'h0001_FD80);
        wr(2'd1, 32'h0000_0480);
        rd(2'd1, v); check("R7 w1c", v, 32'h0001_F900);
        evt_in = 32'h0000_0100;
        wr(2'd1, 32'h0001_F900);
        evt_in = '0;
        rd(2'd1, v); check("R8 set wins", v, 32'h0000_0100);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R7 all cleared", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R9 enable mask", v, 32'h0000_7D80);
        wr(2'd2, 32'h0);
        evt_in = 32'h0000_C000; cyc(); evt_in = '0;
        wr(2'd2, 32'h0000_7D80);
        check("R10 bits 14,15 no irq", {31'd0, irq_o}, 0);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0000_4000);
        evt_in = 32'h0001_0000; cyc(); evt_in = '0;
        check("R10 port3 via enable 14", {31'd0, irq_o}, 1);
        wr(2'd2, 32'h0000_3D80);
        check("R10 port3 masked", {31'd0, irq_o}, 0);
        evt_in = 32'h0000_0800; cyc(); evt_in = '0;
        check("R10 bit 11 irq", {31'd0, irq_o}, 1);
        wr(2'd1, 32'h0000_0800);
        check("R10 irq drops on clear", {31'd0, irq_o}, 0);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_test();
        logic [31:0] v;
        wr(2'd0, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R11 ignored when off", v, 32'h0);
        wr(2'd0, 32'h10);
        wr(2'd3, 32'h0000_0580);
        rd(2'd1, v); check("R11 forced bits", v, 32'h0000_0580);
        rd(2'd3, v); check("R11 test reads zero", v, 32'h0);
        wr(2'd2, 32'h0000_0400);
        check("R11 forced bit interrupts", {31'd0, irq_o}, 1);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_sbr();
        t_core_rst();
        t_tick();
        t_pads();
        t_status();
        t_irq();
        t_test();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule